// File: doc/BRIEF.md
# System Reset Control Port

This block is an 8-bit control register on a simple I/O port bus. Software writes it to ask the platform for a reset. The bus carries an address, an access-size code, read and write strobes, an 8-bit write byte and a wider read-data word. The block answers at one fixed port address, and only to single-byte accesses. It keeps the last byte written so that software can read it back.

One bit of the byte acts as the trigger. A reset request is raised only when that bit goes from 0 to 1, not on every write. A second bit selects the reset type: soft or hard. The block drives a one-cycle request pulse and a level output that carries the selected type. Downstream reset sequencing may handle both types the same way.

Top module: `rst_ctl_port`

## Requirements
- R1: After a synchronous reset, the stored byte is 0x00, `rst_req` is 0, `rst_hard` is 0 and `io_rdata` is all ones.
- R2: A write is accepted when `io_addr` equals 0xCF9 and `io_size` is 0 (one byte). An accepted write stores `io_wdata`. A read accepted by the same rule returns the stored byte, zero-extended, on `io_rdata` in the cycle after the read strobe.
- R3: A write to 0xCF9 with `io_size` 1 (two bytes), 2 (four bytes) or 3 (reserved) leaves the stored byte unchanged and raises no request.
- R4: A write to any other address leaves the stored byte unchanged and raises no request.
- R5: An accepted write with bit 2 set, while the stored bit 2 is 0, makes `rst_req` high for exactly one cycle: the cycle after the write strobe.
- R6: An accepted write with bit 2 set, while the stored bit 2 is already 1, raises no request.
- R7: `rst_hard` shows stored bit 1 (0 = soft, 1 = hard). It is valid in the same cycle as the request pulse.
- R8: A read with the wrong address or size returns all ones on `io_rdata`. So does every cycle that does not follow an accepted read.
- R9: An accepted write that clears bit 2 raises no request. It re-arms the trigger, so a later write with bit 2 set raises a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | Access size code: 0 byte, 1 two bytes, 2 four bytes, 3 reserved |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle reset request pulse |
| rst_hard | output | 1 | Reset type: 1 hard, 0 soft |

## Verification
The trigger logic is exercised with these write sequences:
- Writes with bit 2 clear, which must never fire.
- A first write with bit 2 set, for both type values.
- A repeated write with bit 2 set, which separates edge detection from level detection.
- A clear followed by a set, which shows the trigger re-arms.

Writes of wrong size and to a neighbouring address are chosen so that, if accepted, they would have fired a request. Each is followed by a readback, which shows the stored byte did not change. Reads with a wrong address or size tell the all-ones rejection value apart from real readback data.

// File: rtl/rstport_pkg.sv
package rstport_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } io_size_e;

  localparam int CTL_W    = 8;
  localparam int TRIG_BIT = 2;
  localparam int TYPE_BIT = 1;
endpackage

// File: rtl/rstport_decode.sv
module rstport_decode
  import rstport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_ok,
  output logic              rd_ok
);
  logic hit;

  always_comb begin
    hit   = (addr == PORT_ADDR) && (io_size_e'(size) == SZ_BYTE);
    wr_ok = wr && hit;
    rd_ok = rd && hit;
  end
endmodule

// File: rtl/rstport_ctlreg.sv
module rstport_ctlreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/rstport_trigger.sv
module rstport_trigger #(
  parameter int W        = 8,
  parameter int TRIG_BIT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic [W-1:0] cur,
  output logic         pulse
);
  logic rising;

  always_comb rising = load && din[TRIG_BIT] && !cur[TRIG_BIT];

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= rising;
  end
endmodule

// File: rtl/rstport_rdmux.sv
module rstport_rdmux #(
  parameter int DATA_W = 32,
  parameter int CTL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ok,
  input  logic [CTL_W-1:0]  ctl,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ext;

  generate
    if (DATA_W > CTL_W) begin : g_pad
      always_comb ext = {{(DATA_W-CTL_W){1'b0}}, ctl};
    end else begin : g_trunc
      always_comb ext = ctl[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '1;
    else if (rd_ok) rdata <= ext;
    else            rdata <= '1;
  end
endmodule

// File: rtl/rst_ctl_port.sv
module rst_ctl_port
  import rstport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [CTL_W-1:0]  io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              rst_req,
  output logic              rst_hard
);
  logic wr_ok;
  logic rd_ok;
  logic [CTL_W-1:0] ctl_q;

  rstport_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(io_addr), .size(io_size), .wr(io_wr), .rd(io_rd),
    .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  rstport_ctlreg #(.W(CTL_W)) u_reg (
    .clk(clk), .rst(rst), .load(wr_ok), .din(io_wdata), .q(ctl_q)
  );

  rstport_trigger #(.W(CTL_W), .TRIG_BIT(TRIG_BIT)) u_trig (
    .clk(clk), .rst(rst), .load(wr_ok), .din(io_wdata), .cur(ctl_q),
    .pulse(rst_req)
  );

  rstport_rdmux #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_rd (
    .clk(clk), .rst(rst), .rd_ok(rd_ok), .ctl(ctl_q), .rdata(io_rdata)
  );

  always_comb rst_hard = ctl_q[TYPE_BIT];
endmodule

// File: rtl/rstport_checker.sv
module rstport_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic [1:0]        io_size,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [DATA_W-1:0] io_rdata,
  input logic              rst_req,
  input logic              rst_hard
);
  logic acc;
  always_comb acc = (io_addr == PORT_ADDR) && (io_size == 2'd0);

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  a_r5_has_cause: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(io_wr && acc && io_wdata[2]));

  a_r3_bad_size_quiet: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_size != 2'd0) |=> (!rst_req && $stable(rst_hard)));

  a_r4_other_addr_quiet: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr != PORT_ADDR) |=> (!rst_req && $stable(rst_hard)));

  a_r8_reject_ones: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && acc) |=> (io_rdata == {DATA_W{1'b1}}));

  a_r2_readback_type: assert property (@(posedge clk) disable iff (rst)
    (io_rd && acc) |=> (io_rdata[1] == $past(rst_hard)));

  a_r7_type_changes_on_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(rst_hard) |-> $past(io_wr && acc));
endmodule

bind rst_ctl_port rstport_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_size(io_size),
  .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
  .io_rdata(io_rdata), .rst_req(rst_req), .rst_hard(rst_hard)
);

// File: tb/sim_rst_ctl_port.sv
module sim_rst_ctl_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam logic [15:0] PORT = 16'hCF9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [31:0] io_rdata;
  logic        rst_req;
  logic        rst_hard;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_ctl_port u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_size(io_size),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .rst_req(rst_req), .rst_hard(rst_hard)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Returns at the negedge after the capturing posedge: pulse visible here.
  task automatic do_write(input logic [15:0] a, input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_size = s; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_size = s; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 req after reset", {31'b0, rst_req}, 32'd0);
    check("R1 hard after reset", {31'b0, rst_hard}, 32'd0);
    check("R1 rdata idle after reset", io_rdata, 32'hFFFF_FFFF);
    do_read(PORT, 2'd0, d);
    check("R1 stored byte zero", d, 32'h0000_0000);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    do_write(PORT, 2'd0, 8'h5A);
    check("R2 no pulse bit2 clear", {31'b0, rst_req}, 32'd0);
    check("R7 hard from bit1", {31'b0, rst_hard}, 32'd1);
    do_read(PORT, 2'd0, d);
    check("R2 readback 5A", d, 32'h0000_005A);
    @(negedge clk);
    check("R8 idle after read", io_rdata, 32'hFFFF_FFFF);
    do_write(PORT, 2'd0, 8'hA1);
    check("R7 soft from bit1", {31'b0, rst_hard}, 32'd0);
    do_read(PORT, 2'd0, d);
    check("R2 readback A1", d, 32'h0000_00A1);
  endtask

  task automatic t_trigger_soft();
    do_write(PORT, 2'd0, 8'h04);
    check("R5 pulse on rise", {31'b0, rst_req}, 32'd1);
    check("R7 soft with pulse", {31'b0, rst_hard}, 32'd0);
    @(negedge clk);
    check("R5 pulse one cycle", {31'b0, rst_req}, 32'd0);
  endtask

  task automatic t_no_retrigger();
    logic [31:0] d;
    do_write(PORT, 2'd0, 8'h0C);
    check("R6 no pulse when already set", {31'b0, rst_req}, 32'd0);
    do_read(PORT, 2'd0, d);
    check("R6 byte still stored", d, 32'h0000_000C);
  endtask

  task automatic t_rearm_hard();
    do_write(PORT, 2'd0, 8'h00);
    check("R9 no pulse on clear", {31'b0, rst_req}, 32'd0);
    do_write(PORT, 2'd0, 8'h06);
    check("R9 pulse after rearm", {31'b0, rst_req}, 32'd1);
    check("R7 hard with pulse", {31'b0, rst_hard}, 32'd1);
    @(negedge clk);
    check("R5 hard pulse ends", {31'b0, rst_req}, 32'd0);
  endtask

  task automatic t_bad_size();
    logic [31:0] d;
    do_write(PORT, 2'd0, 8'h00);
    do_write(PORT, 2'd1, 8'h06);
    check("R3 word write no pulse", {31'b0, rst_req}, 32'd0);
    check("R3 word write no type", {31'b0, rst_hard}, 32'd0);
    do_write(PORT, 2'd2, 8'h04);
    check("R3 dword write no pulse", {31'b0, rst_req}, 32'd0);
    do_write(PORT, 2'd3, 8'h04);
    check("R3 reserved size no pulse", {31'b0, rst_req}, 32'd0);
    do_read(PORT, 2'd0, d);
    check("R3 byte unchanged", d, 32'h0000_0000);
  endtask

  task automatic t_bad_addr();
    logic [31:0] d;
    do_write(16'h0CF8, 2'd0, 8'h06);
    check("R4 other addr no pulse", {31'b0, rst_req}, 32'd0);
    do_write(16'h0CFA, 2'd0, 8'h06);
    check("R4 other addr no type", {31'b0, rst_hard}, 32'd0);
    do_read(PORT, 2'd0, d);
    check("R4 byte unchanged", d, 32'h0000_0000);
  endtask

  task automatic t_bad_read();
    logic [31:0] d;
    do_write(PORT, 2'd0, 8'h12);
    do_read(16'h0CF8, 2'd0, d);
    check("R8 wrong addr read", d, 32'hFFFF_FFFF);
    do_read(PORT, 2'd1, d);
    check("R8 word read", d, 32'hFFFF_FFFF);
    do_read(PORT, 2'd2, d);
    check("R8 dword read", d, 32'hFFFF_FFFF);
    do_read(PORT, 2'd0, d);
    check("R2 readback 12", d, 32'h0000_0012);
  endtask

  initial begin
    t_reset();
    t_readback();
    t_trigger_soft();
    t_no_retrigger();
    t_rearm_hard();
    t_bad_size();
    t_bad_addr();
    t_bad_read();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule